// File: doc/BRIEF.md
# Accumulator CPU with ROM

This block is a minimal single-cycle accumulator processor. On every rising clock edge it fetches one instruction word from an internal program ROM at the address held in its program counter and executes it completely. Its state is the program counter, an accumulator, a zero flag and a small general register file. The instructions are an unconditional jump, a branch taken only when the zero flag is set, a store of the accumulator into a register, an add of an immediate to the accumulator, and a bitwise AND of the accumulator with a register.

The program is fixed when the block is elaborated. It is supplied as a flat parameter vector that holds one instruction word per ROM address. The only ports are the clock, a synchronous reset and two observation outputs that show the program counter and the accumulator. The block is meant for small sequencing or demonstration tasks where a hard-wired program is enough.

Top module: `acc_cpu`

## Requirements
- R1: Synchronous reset sets the program counter, the accumulator, the zero flag and every register to zero. The zero flag stays clear after reset even though the accumulator is zero.
- R2: One instruction executes on each rising clock edge while reset is low. `pc_o` and `acc_o` show the registered state that results from it.
- R3: An instruction word is 16 bits. Bits 15:13 hold the opcode, bits 12:10 hold the register address and bits 7:0 hold the operand or target. The opcodes are 001 jump, 010 branch-if-zero, 011 store, 100 add-immediate and 101 AND-register. Opcodes 000, 110 and 111 are undefined.
- R4: A jump loads the program counter with the operand field.
- R5: A branch-if-zero loads the program counter with the operand field when the zero flag is set. When the flag is clear, the program counter advances by one.
- R6: A store writes the accumulator into the register selected by the register-address field. It leaves the accumulator and the zero flag unchanged.
- R7: An add-immediate replaces the accumulator with the accumulator plus the operand, modulo 256.
- R8: An AND-register replaces the accumulator with the bitwise AND of the accumulator and the selected register.
- R9: After every add-immediate or AND-register, the zero flag is set exactly when the new accumulator is zero. Every other instruction leaves the flag unchanged.
- R10: Every instruction other than a jump or a taken branch advances the program counter by one, modulo 256. Undefined opcodes do nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; instructions execute on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 8 | Current program counter |
| acc_o | output | 8 | Current accumulator |

## Verification
Register contents and the zero flag have no port of their own. The flag can only be seen through branch outcomes, and a register can only be seen through an AND into an accumulator of all ones. The hardest case is showing that reset clears the registers. The test program stores a non-zero value, and after a mid-run reset it reruns its first instructions. Those load the accumulator with all ones and AND it with that same register, so a stale value would show up on `acc_o`. A counting loop adds one until a branch on zero exits. This drives the accumulator through all 256 values and checks the branch both not taken and taken. Undefined opcodes, stores and jumps follow flag-setting instructions, and later branches confirm the flag was held across them.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP0 = 3'b000,
      OP_JMP  = 3'b001,
      OP_BZ   = 3'b010,
      OP_ST   = 3'b011,
      OP_ADDI = 3'b100,
      OP_ANDR = 3'b101,
      OP_NOP6 = 3'b110,
      OP_NOP7 = 3'b111
   } opcode_e;

   // decoded control bundle, one strobe per action
   typedef struct packed {
      logic jump;
      logic branch;
      logic reg_we;
      logic acc_add;
      logic acc_and;
   } ctl_t;

endpackage

// File: rtl/acc_cpu_rom.sv
module acc_cpu_rom #(
   parameter int INSTR_W   = 16,
   parameter int PC_W      = 8,
   parameter int ROM_DEPTH = 32,
   parameter logic [ROM_DEPTH*INSTR_W-1:0] ROM_IMAGE = '0
) (
   input  logic [PC_W-1:0]    addr,
   output logic [INSTR_W-1:0] word
);

   localparam int IMG_W = ROM_DEPTH * INSTR_W;
   localparam int IDX_W = (IMG_W > 2) ? $clog2(IMG_W) : 1;
   localparam logic [PC_W:0] DEPTH_V = (PC_W+1)'(ROM_DEPTH);

   logic [IDX_W-1:0] base;

   always_comb begin
      base = IDX_W'(addr) * IDX_W'(INSTR_W);
   end

   generate
      if (ROM_DEPTH == (1 << PC_W)) begin : g_full
         // every address maps to a stored word
         assign word = ROM_IMAGE[base +: INSTR_W];
      end else begin : g_partial
         // addresses past the image read as an all-zero word (no-op)
         logic in_range;
         assign in_range = ({1'b0, addr} < DEPTH_V);
         assign word = in_range ? ROM_IMAGE[base +: INSTR_W] : '0;
      end
   endgenerate

endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
   import acc_cpu_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int REG_AW  = 3,
   parameter int DATA_W  = 8
) (
   input  logic [INSTR_W-1:0] word,
   output logic [REG_AW-1:0]  reg_sel,
   output logic [DATA_W-1:0]  operand,
   output ctl_t               ctl
);

   localparam int GAP_W = INSTR_W - OPC_W - REG_AW - DATA_W;

   opcode_e opc;

   assign opc     = opcode_e'(word[INSTR_W-1 -: OPC_W]);
   assign reg_sel = word[INSTR_W-OPC_W-1 -: REG_AW];
   assign operand = word[DATA_W-1:0];

   generate
      if (GAP_W > 0) begin : g_gap
         logic unused_gap;
         assign unused_gap = ^word[DATA_W +: GAP_W];
      end
   endgenerate

   always_comb begin
      ctl = '0;
      unique case (opc)
         OP_JMP:  ctl.jump    = 1'b1;
         OP_BZ:   ctl.branch  = 1'b1;
         OP_ST:   ctl.reg_we  = 1'b1;
         OP_ADDI: ctl.acc_add = 1'b1;
         OP_ANDR: ctl.acc_and = 1'b1;
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile #(
   parameter int DATA_W = 8,
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [REG_AW-1:0] sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int NREG = 1 << REG_AW;

   logic [DATA_W-1:0] regs [NREG];

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               regs[i] <= '0;
            end else if (we && (sel == REG_AW'(i))) begin
               regs[i] <= wdata;
            end
         end
      end
   endgenerate

   assign rdata = regs[sel];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  ctl_t              ctl,
   input  logic [DATA_W-1:0] acc,
   input  logic              zero,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] acc_nxt,
   output logic              zero_nxt
);

   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] conj;

   assign sum  = acc + operand;
   assign conj = acc & rdata;

   always_comb begin
      acc_nxt  = acc;
      zero_nxt = zero;
      if (ctl.acc_add) begin
         acc_nxt  = sum;
         zero_nxt = (sum == '0);
      end else if (ctl.acc_and) begin
         acc_nxt  = conj;
         zero_nxt = (conj == '0);
      end
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int REG_AW    = 3,
   parameter int PC_W      = 8,
   parameter int INSTR_W   = 16,
   parameter int ROM_DEPTH = 32,
   parameter logic [ROM_DEPTH*INSTR_W-1:0] ROM_IMAGE = '0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [PC_W-1:0]   pc_o,
   output logic [DATA_W-1:0] acc_o
);

   // elaboration-time parameter checks
   generate
      if (INSTR_W < OPC_W + REG_AW + DATA_W) begin : g_bad_fmt
         $error("acc_cpu: INSTR_W too small for the instruction fields");
      end
      if (PC_W > DATA_W) begin : g_bad_pc
         $error("acc_cpu: PC_W must not exceed the operand width");
      end
      if (ROM_DEPTH < 1 || ROM_DEPTH > (1 << PC_W)) begin : g_bad_depth
         $error("acc_cpu: ROM_DEPTH outside 1 .. 2**PC_W");
      end
   endgenerate

   logic [PC_W-1:0]    pc_q, pc_d;
   logic [DATA_W-1:0]  acc_q, acc_d;
   logic               zero_q, zero_d;
   logic [INSTR_W-1:0] instr;
   logic [REG_AW-1:0]  reg_sel;
   logic [DATA_W-1:0]  operand;
   logic [DATA_W-1:0]  reg_rd;
   ctl_t               ctl;
   logic               take;

   acc_cpu_rom #(
      .INSTR_W  (INSTR_W),
      .PC_W     (PC_W),
      .ROM_DEPTH(ROM_DEPTH),
      .ROM_IMAGE(ROM_IMAGE)
   ) u_rom (
      .addr(pc_q),
      .word(instr)
   );

   acc_cpu_decode #(
      .INSTR_W(INSTR_W),
      .REG_AW (REG_AW),
      .DATA_W (DATA_W)
   ) u_dec (
      .word   (instr),
      .reg_sel(reg_sel),
      .operand(operand),
      .ctl    (ctl)
   );

   acc_cpu_regfile #(
      .DATA_W(DATA_W),
      .REG_AW(REG_AW)
   ) u_rf (
      .clk  (clk),
      .rst  (rst),
      .we   (ctl.reg_we),
      .sel  (reg_sel),
      .wdata(acc_q),
      .rdata(reg_rd)
   );

   acc_cpu_alu #(
      .DATA_W(DATA_W)
   ) u_alu (
      .ctl     (ctl),
      .acc     (acc_q),
      .zero    (zero_q),
      .operand (operand),
      .rdata   (reg_rd),
      .acc_nxt (acc_d),
      .zero_nxt(zero_d)
   );

   // next program counter: operand target or sequential step
   assign take = ctl.jump | (ctl.branch & zero_q);
   assign pc_d = take ? operand[PC_W-1:0] : pc_q + PC_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= '0;
         acc_q  <= '0;
         zero_q <= 1'b0;
      end else begin
         pc_q   <= pc_d;
         acc_q  <= acc_d;
         zero_q <= zero_d;
      end
   end

   assign pc_o  = pc_q;
   assign acc_o = acc_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int PC_W    = 8,
   parameter int INSTR_W = 16
) (
   input logic               clk,
   input logic               rst,
   input logic [PC_W-1:0]    pc,
   input logic [DATA_W-1:0]  acc,
   input logic               zero,
   input logic [INSTR_W-1:0] instr,
   input logic [DATA_W-1:0]  rdata
);

   logic [OPC_W-1:0]  op;
   logic [DATA_W-1:0] opnd;

   assign op   = instr[INSTR_W-1 -: OPC_W];
   assign opnd = instr[DATA_W-1:0];

   assert_reset_R1: assert property (@(posedge clk)
      rst |=> (pc == '0 && acc == '0 && !zero));

   assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
      (op == OP_JMP) |=> (pc == $past(opnd[PC_W-1:0])));

   assert_branch_R5: assert property (@(posedge clk) disable iff (rst)
      (op == OP_BZ && zero) |=> (pc == $past(opnd[PC_W-1:0])));

   assert_store_R6: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ST) |=> ($stable(acc) && $stable(zero)));

   assert_addi_R7: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ADDI) |=> (acc == $past(acc + opnd)));

   assert_andr_R8: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ANDR) |=> (acc == $past(acc & rdata)));

   assert_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ADDI || op == OP_ANDR) |=> (zero == (acc == '0)));

   assert_zero_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (op != OP_ADDI && op != OP_ANDR) |=> $stable(zero));

   assert_step_R10: assert property (@(posedge clk) disable iff (rst)
      (op != OP_JMP && !(op == OP_BZ && zero)) |=> (pc == $past(pc) + PC_W'(1)));

endmodule

bind acc_cpu acc_cpu_chk #(
   .DATA_W (DATA_W),
   .PC_W   (PC_W),
   .INSTR_W(INSTR_W)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .pc   (pc_q),
   .acc  (acc_q),
   .zero (zero_q),
   .instr(instr),
   .rdata(reg_rd)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

   localparam int DEPTH = 32;

   // R3 encoding: {opcode[15:13], reg[12:10], 2'b00, operand[7:0]}
   function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] ra,
                                       input logic [7:0] v);
      return {op, ra, 2'b00, v};
   endfunction

   function automatic logic [DEPTH*16-1:0] build();
      logic [DEPTH*16-1:0] img;
      img = '0;
      img[ 0*16 +: 16] = enc(3'b010, 3'd0, 8'd3);    // BZ 3, flag clear after reset
      img[ 1*16 +: 16] = enc(3'b100, 3'd0, 8'hFF);   // ADDI FF
      img[ 2*16 +: 16] = enc(3'b101, 3'd6, 8'h00);   // ANDR r6 (cleared)
      img[ 3*16 +: 16] = enc(3'b010, 3'd0, 8'd5);    // BZ 5 taken
      img[ 4*16 +: 16] = enc(3'b100, 3'd0, 8'h77);   // skipped
      img[ 5*16 +: 16] = enc(3'b100, 3'd0, 8'h03);
      img[ 6*16 +: 16] = enc(3'b011, 3'd1, 8'h00);   // ST r1
      img[ 7*16 +: 16] = enc(3'b100, 3'd0, 8'hFF);   // wraps to 2
      img[ 8*16 +: 16] = enc(3'b011, 3'd2, 8'h00);   // ST r2
      img[ 9*16 +: 16] = enc(3'b101, 3'd1, 8'h00);   // ANDR r1
      img[10*16 +: 16] = enc(3'b100, 3'd0, 8'hFE);   // -> 0
      img[11*16 +: 16] = enc(3'b100, 3'd0, 8'hA5);
      img[12*16 +: 16] = enc(3'b011, 3'd6, 8'h00);   // ST r6
      img[13*16 +: 16] = enc(3'b100, 3'd0, 8'h5A);   // -> FF
      img[14*16 +: 16] = enc(3'b101, 3'd6, 8'h00);   // ANDR r6 -> A5
      img[15*16 +: 16] = enc(3'b110, 3'd5, 8'h12);   // undefined
      img[16*16 +: 16] = enc(3'b111, 3'd2, 8'h34);   // undefined
      img[17*16 +: 16] = enc(3'b100, 3'd0, 8'h5B);   // -> 0
      img[18*16 +: 16] = enc(3'b100, 3'd0, 8'h01);   // counting loop
      img[19*16 +: 16] = enc(3'b010, 3'd0, 8'd21);
      img[20*16 +: 16] = enc(3'b001, 3'd0, 8'd18);   // JMP 18
      img[21*16 +: 16] = enc(3'b101, 3'd2, 8'h00);   // ANDR r2 -> 0
      img[22*16 +: 16] = enc(3'b000, 3'd7, 8'h99);   // undefined
      img[23*16 +: 16] = enc(3'b011, 3'd0, 8'h00);   // ST r0
      img[24*16 +: 16] = enc(3'b010, 3'd0, 8'd26);   // flag held -> taken
      img[25*16 +: 16] = enc(3'b100, 3'd0, 8'h11);   // skipped
      img[26*16 +: 16] = enc(3'b001, 3'd0, 8'd26);   // halt loop
      return img;
   endfunction

   localparam logic [DEPTH*16-1:0] PROG = build();

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] pc_o;
   logic [7:0] acc_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] m_pc, m_acc;
   logic       m_z;
   logic [7:0] m_r [8];

   always #2 clk = ~clk;

   acc_cpu #(
      .DATA_W   (8),
      .REG_AW   (3),
      .PC_W     (8),
      .INSTR_W  (16),
      .ROM_DEPTH(DEPTH),
      .ROM_IMAGE(PROG)
   ) u_dut (
      .clk  (clk),
      .rst  (rst),
      .pc_o (pc_o),
      .acc_o(acc_o)
   );

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc = '0;
      m_acc = '0;
      m_z = 1'b0;
      for (int i = 0; i < 8; i++) m_r[i] = '0;
   endtask

   // one instruction of the expected behaviour, then compare the ports
   task automatic step_and_check();
      logic [15:0] w;
      logic [2:0]  op, ra;
      logic [7:0]  v;
      string       tag;
      w  = (m_pc < DEPTH) ? PROG[int'(m_pc)*16 +: 16] : 16'h0000;
      op = w[15:13];
      ra = w[12:10];
      v  = w[7:0];
      case (op)
         3'b001: begin tag = "R4 jump"; m_pc = v; end
         3'b010: begin tag = "R5 branch"; m_pc = m_z ? v : m_pc + 8'd1; end
         3'b011: begin tag = "R6 store"; m_r[ra] = m_acc; m_pc = m_pc + 8'd1; end
         3'b100: begin
            tag = "R7 R9 addi";
            m_acc = m_acc + v;
            m_z = (m_acc == 8'h00);
            m_pc = m_pc + 8'd1;
         end
         3'b101: begin
            tag = "R8 R9 and";
            m_acc = m_acc & m_r[ra];
            m_z = (m_acc == 8'h00);
            m_pc = m_pc + 8'd1;
         end
         default: begin tag = "R3 R10 undefined"; m_pc = m_pc + 8'd1; end
      endcase
      check8({"R2 pc ", tag}, pc_o, m_pc);
      check8({"R2 acc ", tag}, acc_o, m_acc);
   endtask

   initial begin
      model_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check8("R1 reset pc", pc_o, 8'h00);
      check8("R1 reset acc", acc_o, 8'h00);
      rst = 1'b0;
      // full run: covers counting loop through all accumulator values
      for (int n = 0; n < 900; n++) begin
         @(posedge clk);
         @(negedge clk);
         step_and_check();
      end
      check8("R4 halt loop pc", pc_o, 8'd26);
      // mid-run reset: R1 state and registers must be cleared (r6 held A5)
      rst = 1'b1;
      @(negedge clk);
      check8("R1 mid reset pc", pc_o, 8'h00);
      check8("R1 mid reset acc", acc_o, 8'h00);
      model_reset();
      rst = 1'b0;
      for (int n = 0; n < 40; n++) begin
         @(posedge clk);
         @(negedge clk);
         step_and_check();
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule